// File: doc/BRIEF.md
# Output Virtual-Channel Recycling Allocator

This block controls virtual-channel ownership on one output link of a synchronous packet router. Control packets move ahead of the data and raise a request on behalf of a packet that needs a channel on this output. The block chooses one requester per cycle in round-robin fashion. It hands that requester the oldest free downstream channel identifier. A channel comes back only when the tail flit of the packet that holds it leaves through the output.

Free identifiers sit in a first-in first-out queue. Each channel that comes back is appended to that queue and is also sent out on a recovery-order channel with a valid/ready handshake. The router at the far end of the link therefore learns the order in which identifiers will be handed out again. It can use that order to steer each new assignment, together with the packet's output port, to the right input buffer without any extra tag on the link. While the recovery channel is stalled, the block refuses further releases.

Top module: `vc_recycle_alloc`

## Requirements
- R1: After reset no grant is shown, `rec_valid_o` is 0 and `rel_ready_o` is 1. All channels are free, and the first grants issue identifiers 0, 1, 2, 3 in that order.
- R2: `gnt_o` is zero or one-hot, and `gnt_vc_o` is valid only in a cycle where `gnt_o` is non-zero. When every channel is owned, no grant is made, and no identifier is ever handed to a second owner.
- R3: When several requests are pending, the winner is the first requester after the previous winner in ascending index order, wrapping around. After reset, requester 0 has the highest priority.
- R4: A grant appears on `gnt_o`/`gnt_vc_o` in the cycle after the edge at which the request was sampled. Returned identifiers are reissued in exactly the order in which they were released.
- R5: A release and a grant in the same cycle are both accepted. An identifier released while the free queue is empty is not granted in that cycle; it is granted in the next cycle.
- R6: Every accepted release shows up as `rec_valid_o` with `rec_vc_o` equal to the released identifier in the following cycle. While `rec_ready_i` is low, `rec_valid_o` stays high and `rec_vc_o` does not change.
- R7: While `rec_valid_o` is high and `rec_ready_i` is low, `rel_ready_o` is 0. A release offered during that time is ignored: it is neither reported nor queued.
- R8: A requester whose grant is currently shown on `gnt_o` is not granted again at the next edge, even if its request is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ | Per-requester level request for a new channel, held until the grant is seen |
| gnt_o | output | NUM_REQ | Registered one-hot grant |
| gnt_vc_o | output | VC_W | Identifier granted with `gnt_o` |
| rel_valid_i | input | 1 | Tail flit of an owning packet departed |
| rel_vc_i | input | VC_W | Identifier being released |
| rel_ready_o | output | 1 | Release accepted this cycle when high |
| rec_valid_o | output | 1 | Recovery-order entry available |
| rec_vc_o | output | VC_W | Recovered identifier, in release order |
| rec_ready_i | input | 1 | Far end takes the recovery entry |

## Verification
The hardest case to reach is a release that arrives in the very cycle the free queue is empty while a request is already waiting. This is the only point where a same-cycle bypass would show up. The stimulus first hands out all four channels and keeps one request raised. It then offers a single release and samples the grant output on the edge where the release is taken and again on the edge after it. A second hard case is a stalled recovery channel. The bench holds the ready low, offers a release that must be refused, and then proves from the ports that it was refused: once the stall clears, a new requester gets no identifier.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  parameter int VCR_NUM_VC  = 4;
  parameter int VCR_NUM_REQ = 5;

  function automatic int unsigned vcr_wrap(input int unsigned v, input int unsigned n);
    return (v >= n) ? v - n : v;
  endfunction
endpackage

// File: rtl/vcr_free_fifo.sv
module vcr_free_fifo #(
  parameter int DEPTH = 4,
  parameter int IDW   = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic           pop,
  output logic [IDW-1:0] head_id,
  output logic [CW-1:0]  count
);
  logic [IDW-1:0] mem [DEPTH];
  logic [PW-1:0]  rd_q, wr_q;
  logic [CW-1:0]  cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= IDW'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      if (push) begin
        mem[wr_q] <= push_id;
        wr_q      <= step(wr_q);
      end
      if (pop) rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_id = mem[rd_q];
  assign count   = cnt_q;
endmodule

// File: rtl/vcr_rr_arb.sv
module vcr_rr_arb #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  pick,
  output logic [IW-1:0] pick_idx
);
  import vcr_pkg::*;
  logic [IW-1:0] last_q;
  int unsigned   idx;

  // walk from farthest to nearest so the nearest pending request wins
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    idx      = 0;
    for (int off = N; off >= 1; off--) begin
      idx = vcr_wrap(int'(last_q) + off, N);
      if (req[idx]) begin
        pick      = '0;
        pick[idx] = 1'b1;
        pick_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= IW'(N - 1);
    else if (take) last_q <= pick_idx;
  end
endmodule

// File: rtl/vcr_recov_reg.sv
module vcr_recov_reg #(
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [IDW-1:0] load_id,
  input  logic           ready_i,
  output logic           can_load,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  logic           valid_q;
  logic [IDW-1:0] id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      id_q    <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      id_q    <= load_id;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign can_load = !valid_q || ready_i;
  assign valid_o  = valid_q;
  assign id_o     = id_q;
endmodule

// File: rtl/vc_recycle_alloc.sv
module vc_recycle_alloc #(
  parameter int NUM_VC  = vcr_pkg::VCR_NUM_VC,
  parameter int NUM_REQ = vcr_pkg::VCR_NUM_REQ,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W  = $clog2(NUM_VC + 1),
  localparam int RI_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic [VC_W-1:0]    gnt_vc_o,
  input  logic               rel_valid_i,
  input  logic [VC_W-1:0]    rel_vc_i,
  output logic               rel_ready_o,
  output logic               rec_valid_o,
  output logic [VC_W-1:0]    rec_vc_o,
  input  logic               rec_ready_i
);
  logic [NUM_REQ-1:0] gnt_q, req_eff, arb_pick;
  logic [RI_W-1:0]    arb_idx;
  logic [VC_W-1:0]    gnt_vc_q, head_id;
  logic [CNT_W-1:0]   free_cnt;
  logic               pop, rel_fire, rec_can;

  // requesters whose grant is still on display are acknowledged, not re-served
  assign req_eff  = req_i & ~gnt_q;
  assign pop      = (|req_eff) && (free_cnt != '0);
  assign rel_fire = rel_valid_i && rec_can;

  vcr_rr_arb #(.N(NUM_REQ)) u_arb (
    .clk(clk), .rst(rst), .req(req_eff), .take(pop),
    .pick(arb_pick), .pick_idx(arb_idx)
  );

  vcr_free_fifo #(.DEPTH(NUM_VC), .IDW(VC_W)) u_free (
    .clk(clk), .rst(rst), .push(rel_fire), .push_id(rel_vc_i),
    .pop(pop), .head_id(head_id), .count(free_cnt)
  );

  vcr_recov_reg #(.IDW(VC_W)) u_recov (
    .clk(clk), .rst(rst), .load(rel_fire), .load_id(rel_vc_i),
    .ready_i(rec_ready_i), .can_load(rec_can),
    .valid_o(rec_valid_o), .id_o(rec_vc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q    <= '0;
      gnt_vc_q <= '0;
    end else begin
      gnt_q <= pop ? arb_pick : '0;
      if (pop) gnt_vc_q <= head_id;
    end
  end

  assign gnt_o       = gnt_q;
  assign gnt_vc_o    = gnt_vc_q;
  assign rel_ready_o = rec_can;
endmodule

// File: rtl/vc_recycle_alloc_chk.sv
module vc_recycle_alloc_chk #(
  parameter int NUM_VC  = 4,
  parameter int NUM_REQ = 5,
  parameter int VC_W    = 2,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] gnt_o,
  input logic [VC_W-1:0]    rec_vc_o,
  input logic               rec_valid_o,
  input logic               rec_ready_i,
  input logic               rel_ready_o,
  input logic [CNT_W-1:0]   free_cnt
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_o));
  // R2
  no_grant_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (free_cnt == '0) |=> (gnt_o == '0));
  // R1
  free_bound_chk: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(NUM_VC));
  // R6
  rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_vc_o)));
  // R7
  rel_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !rec_ready_i) |-> !rel_ready_o);
  // R8
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0) |=> ((gnt_o & $past(gnt_o)) == '0));
endmodule

bind vc_recycle_alloc vc_recycle_alloc_chk #(
  .NUM_VC(NUM_VC), .NUM_REQ(NUM_REQ), .VC_W(VC_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst(rst), .gnt_o(gnt_o), .rec_vc_o(rec_vc_o),
  .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
  .rel_ready_o(rel_ready_o), .free_cnt(free_cnt)
);

// File: tb/test_vc_recycle_alloc.sv
module test_vc_recycle_alloc;
  localparam int NV = 4, NR = 5, VW = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic [NR-1:0] req_i = '0;
  logic [NR-1:0] gnt_o;
  logic [VW-1:0] gnt_vc_o, rel_vc_i = '0, rec_vc_o;
  logic rel_valid_i = 1'b0, rel_ready_o, rec_valid_o, rec_ready_i = 1'b1;
  int checks = 0, errors = 0, cycles = 0;
  bit owned [NV];

  always #2 clk = ~clk;

  vc_recycle_alloc #(.NUM_VC(NV), .NUM_REQ(NR)) i_vc_recycle_alloc (
    .clk(clk), .rst(rst), .req_i(req_i), .gnt_o(gnt_o), .gnt_vc_o(gnt_vc_o),
    .rel_valid_i(rel_valid_i), .rel_vc_i(rel_vc_i), .rel_ready_o(rel_ready_o),
    .rec_valid_o(rec_valid_o), .rec_vc_o(rec_vc_o), .rec_ready_i(rec_ready_i)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // raise a request, wait for its grant, verify the identifier and ownership
  task automatic get_vc(input int port, input int exp_vc, input string rq);
    bit got = 1'b0;
    @(negedge clk);
    req_i[port] = 1'b1;
    for (int i = 0; i < 6 && !got; i++) begin
      @(negedge clk);
      if (gnt_o[port]) got = 1'b1;
    end
    req_i[port] = 1'b0;
    chk(got, rq, "grant seen", int'(got), 1);
    if (got) begin
      chk(gnt_vc_o == VW'(exp_vc), rq, "granted id", int'(gnt_vc_o), exp_vc);
      chk(!owned[gnt_vc_o], "R2", "id already owned", int'(owned[gnt_vc_o]), 0);
      owned[gnt_vc_o] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic release_vc(input int vc);
    @(negedge clk);
    chk(rel_ready_o, "R7", "release ready", int'(rel_ready_o), 1);
    rel_valid_i = 1'b1;
    rel_vc_i    = VW'(vc);
    @(negedge clk);
    rel_valid_i = 1'b0;
    owned[vc]   = 1'b0;
    chk(rec_valid_o, "R6", "recovery valid", int'(rec_valid_o), 1);
    chk(rec_vc_o == VW'(vc), "R6", "recovery id", int'(rec_vc_o), vc);
  endtask

  task automatic t_reset();
    chk(gnt_o == '0, "R1", "gnt after reset", int'(gnt_o), 0);
    chk(!rec_valid_o, "R1", "rec_valid after reset", int'(rec_valid_o), 0);
    chk(rel_ready_o, "R1", "rel_ready after reset", int'(rel_ready_o), 1);
  endtask

  task automatic t_init_order();
    for (int v = 0; v < NV; v++) get_vc(0, v, "R1");
  endtask

  task automatic t_empty_release();
    @(negedge clk);
    req_i[1] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(gnt_o == '0, "R2", "grant while all owned", int'(gnt_o), 0);
    end
    rel_valid_i = 1'b1;
    rel_vc_i    = 2'd2;
    @(negedge clk);
    rel_valid_i = 1'b0;
    owned[2]    = 1'b0;
    chk(gnt_o == '0, "R5", "same-cycle grant of released id", int'(gnt_o), 0);
    chk(rec_valid_o && rec_vc_o == 2'd2, "R6", "recovery id", int'(rec_vc_o), 2);
    @(negedge clk);
    req_i[1] = 1'b0;
    chk(gnt_o == 5'b00010, "R5", "grant next cycle", int'(gnt_o), 2);
    chk(gnt_vc_o == 2'd2, "R5", "granted id", int'(gnt_vc_o), 2);
    owned[2] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_round_robin();
    release_vc(1);
    release_vc(3);
    @(negedge clk);
    req_i = 5'b10101;
    @(negedge clk);
    chk(gnt_o == 5'b00100, "R3", "first rr winner", int'(gnt_o), 4);
    chk(gnt_vc_o == 2'd1, "R4", "first reissued id", int'(gnt_vc_o), 1);
    req_i[2] = 1'b0;
    owned[1] = 1'b1;
    @(negedge clk);
    chk(gnt_o == 5'b10000, "R3", "second rr winner", int'(gnt_o), 16);
    chk(gnt_vc_o == 2'd3, "R4", "second reissued id", int'(gnt_vc_o), 3);
    req_i[4] = 1'b0;
    owned[3] = 1'b1;
    @(negedge clk);
    chk(gnt_o == '0, "R2", "grant with empty queue", int'(gnt_o), 0);
    req_i = '0;
  endtask

  task automatic t_same_cycle();
    release_vc(0);
    @(negedge clk);
    req_i[3]    = 1'b1;
    rel_valid_i = 1'b1;
    rel_vc_i    = 2'd2;
    @(negedge clk);
    req_i[3]    = 1'b0;
    rel_valid_i = 1'b0;
    owned[2]    = 1'b0;
    chk(gnt_o == 5'b01000 && gnt_vc_o == 2'd0, "R5", "grant beside release", int'(gnt_vc_o), 0);
    owned[0] = 1'b1;
    chk(rec_valid_o && rec_vc_o == 2'd2, "R5", "release beside grant", int'(rec_vc_o), 2);
    @(negedge clk);
    get_vc(3, 2, "R5");
  endtask

  task automatic t_stall();
    @(negedge clk);
    rec_ready_i = 1'b0;
    release_vc(1);
    chk(!rel_ready_o, "R7", "ready while stalled", int'(rel_ready_o), 0);
    rel_valid_i = 1'b1;
    rel_vc_i    = 2'd3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rec_valid_o && rec_vc_o == 2'd1, "R6", "held recovery id", int'(rec_vc_o), 1);
    end
    rel_valid_i = 1'b0;
    rec_ready_i = 1'b1;
    @(negedge clk);
    chk(!rec_valid_o, "R6", "recovery drained", int'(rec_valid_o), 0);
    get_vc(2, 1, "R4");
    req_i[4] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(gnt_o == '0, "R7", "refused release queued", int'(gnt_o), 0);
    end
    req_i[4] = 1'b0;
  endtask

  task automatic t_ack_mask();
    release_vc(3);
    release_vc(1);
    @(negedge clk);
    req_i[1] = 1'b1;
    @(negedge clk);
    chk(gnt_o == 5'b00010 && gnt_vc_o == 2'd3, "R8", "first grant", int'(gnt_vc_o), 3);
    owned[3] = 1'b1;
    @(negedge clk);
    chk(gnt_o == '0, "R8", "repeat grant while shown", int'(gnt_o), 0);
    @(negedge clk);
    req_i[1] = 1'b0;
    chk(gnt_o == 5'b00010 && gnt_vc_o == 2'd1, "R8", "later grant", int'(gnt_vc_o), 1);
    owned[1] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) owned[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init_order();
    t_empty_release();
    t_round_robin();
    t_same_cycle();
    t_stall();
    t_ack_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule